// File: doc/BRIEF.md
# Scan-synchronized sample capture unit

This block sits behind a multichannel converter that runs continuously at its own rate. Channel words arrive one at a time on a word strobe, and the first word of each conversion cycle carries a start-of-scan mark. The block assembles these words into a scan. It keeps the newest scan whose words have all arrived. When a scan event occurs, it copies that scan into an output register and raises a one-cycle valid pulse. A scan that is still being assembled is never presented.

Two sources of scan events are available, and the `mode_div` input selects between them. In gated mode the converter runs free and the active edge of an external scan clock picks the latest finished conversion. The output is then aligned to the scan clock to within one conversion period (about 8.33 µs at a 120 kHz conversion rate). In divided mode a shared master enable pulse arrives at eight times the scan rate, and an internal counter divides it by `DIV_RATIO` to make the scan event. The channel count, word width, divide ratio and scan-clock polarity are all parameters.

Top module: `scan_capture_top`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `out_valid` is 0 and `out_scan` is all zeros.
- R2: A scan is complete only after `NUM_CH` accepted words. The first of these carries `in_sof`=1 and the rest follow with `in_sof`=0. The k-th word of the scan (k from 0) appears at `out_scan[k*WORD_W +: WORD_W]`.
- R3: A word with `in_sof`=1 drops any partial scan and starts a new one. Words with `in_sof`=0 that arrive when no scan is in progress are ignored.
- R4: In gated mode (`mode_div`=0), a rising edge of `scan_clk` is detected on the clock edge where `scan_clk` is first sampled high after being sampled low. On the following cycle, `out_valid` is 1 for one cycle.
- R5: A scan event captures the newest complete scan. Words of a scan still in progress do not affect the captured value.
- R6: If a scan's final word and a scan event are sampled on the same clock edge, the capture holds the scan that this word completes.
- R7: A scan event that occurs before any complete scan exists since reset produces no `out_valid`.
- R8: In divided mode (`mode_div`=1), a scan event happens on every `DIV_RATIO`-th clock edge at which `master_tick` is sampled high, with `DIV_RATIO`=8 by default. The tick counter restarts at zero on reset and whenever `mode_div` is 0. In this mode `scan_clk` is ignored.
- R9: In gated mode, `master_tick` has no effect.
- R10: `out_scan` changes only on a cycle in which `out_valid` is 1, and it holds its value between events.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_div | input | 1 | 0 = gated by scan clock, 1 = divided master tick |
| scan_clk | input | 1 | External scan clock, sampled by `clk` |
| master_tick | input | 1 | One-cycle pulse of the 8x master clock |
| in_valid | input | 1 | Channel word strobe |
| in_sof | input | 1 | Marks the first word of a scan |
| in_word | input | WORD_W | Channel word |
| out_valid | output | 1 | One-cycle pulse when a scan is latched |
| out_scan | output | NUM_CH*WORD_W | Latched scan, channel k at bits k*WORD_W |

## Verification
The bench builds the block with its default parameters: 16 channels of 16 bits, a divide ratio of 8 and rising-edge capture. This configuration is small enough to sweep every possible length of a trailing partial scan, from 0 to 15 words, against a complete scan latched before it. The divided mode is driven with irregular tick spacing while the scan clock toggles, so the bench can predict every eighth tick by arithmetic. A final-word-plus-edge collision, a counter restart caused by a mode change, and a capture attempted right after reset are also within reach.

// File: rtl/scan_cap_pkg.sv
package scan_cap_pkg;
   typedef enum logic {
      SYNC_GATED   = 1'b0,
      SYNC_DIVIDED = 1'b1
   } sync_mode_e;
endpackage

// File: rtl/scan_assembler.sv
module scan_assembler #(
   parameter int NUM_CH = 16,
   parameter int WORD_W = 16
) (
   input  logic                                 clk,
   input  logic                                 rst,
   input  logic                                 in_valid,
   input  logic                                 in_sof,
   input  logic [WORD_W-1:0]                    in_word,
   output logic [NUM_CH-1:0][WORD_W-1:0]        scan_now,
   output logic                                 scan_done,
   output logic [NUM_CH-1:0][WORD_W-1:0]        held_scan,
   output logic                                 held_ok
);
   localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CH - 1);

   logic [NUM_CH-1:0][WORD_W-1:0] work_q, work_d;
   logic [IDX_W-1:0]              idx_q, pos;
   logic                          active_q, take;

   always_comb begin
      work_d = work_q;
      take   = in_valid && (in_sof || active_q);
      pos    = in_sof ? '0 : idx_q;
      if (take) work_d[pos] = in_word;
      scan_done = take && (pos == LAST_IDX);
   end

   assign scan_now = work_d;

   always_ff @(posedge clk) begin
      if (rst) begin
         work_q    <= '0;
         idx_q     <= '0;
         active_q  <= 1'b0;
         held_scan <= '0;
         held_ok   <= 1'b0;
      end else if (take) begin
         work_q <= work_d;
         if (scan_done) begin
            active_q  <= 1'b0;
            idx_q     <= '0;
            held_scan <= work_d;
            held_ok   <= 1'b1;
         end else begin
            active_q <= 1'b1;
            idx_q    <= pos + 1'b1;
         end
      end
   end

   // R2: a scan can only finish on a continuation word of a scan in progress
   p_done_in_run_r2: assert property (@(posedge clk) disable iff (rst)
      scan_done |-> (active_q && !in_sof));

   // R3: when no scan is running the index has been returned to zero
   p_idle_idx_r3: assert property (@(posedge clk) disable iff (rst)
      !active_q |-> (idx_q == '0));
endmodule

// File: rtl/scan_event_gen.sv
module scan_event_gen #(
   parameter int DIV_RATIO   = 8,
   parameter bit SCAN_RISING = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic mode_div,
   input  logic scan_clk,
   input  logic master_tick,
   output logic evt
);
   import scan_cap_pkg::*;

   localparam int CNT_W = $clog2(DIV_RATIO);
   localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(DIV_RATIO - 1);

   sync_mode_e       mode;
   logic             prev_q, edge_evt, div_evt;
   logic [CNT_W-1:0] cnt_q;

   assign mode = sync_mode_e'(mode_div);

   always_ff @(posedge clk) begin
      if (rst) prev_q <= 1'b0;
      else     prev_q <= scan_clk;
   end

   generate
      if (SCAN_RISING) begin : g_rise
         assign edge_evt = scan_clk && !prev_q;
      end else begin : g_fall
         assign edge_evt = !scan_clk && prev_q;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst || mode != SYNC_DIVIDED) cnt_q <= '0;
      else if (master_tick)            cnt_q <= (cnt_q == CNT_TOP) ? '0 : cnt_q + 1'b1;
   end

   assign div_evt = master_tick && (cnt_q == CNT_TOP);
   assign evt     = (mode == SYNC_DIVIDED) ? div_evt : edge_evt;

   // R8: divided-mode events fall only on master ticks
   p_div_on_tick_r8: assert property (@(posedge clk) disable iff (rst)
      (mode_div && evt) |-> master_tick);

   // R4: gated-mode events fall only when the scan clock sits at its active level
   p_gated_level_r4: assert property (@(posedge clk) disable iff (rst)
      (!mode_div && evt) |-> (scan_clk == SCAN_RISING));
endmodule

// File: rtl/scan_capture_reg.sv
module scan_capture_reg #(
   parameter int NUM_CH = 16,
   parameter int WORD_W = 16
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic                          evt,
   input  logic                          scan_done,
   input  logic [NUM_CH-1:0][WORD_W-1:0] scan_now,
   input  logic [NUM_CH-1:0][WORD_W-1:0] held_scan,
   input  logic                          held_ok,
   output logic                          out_valid,
   output logic [NUM_CH-1:0][WORD_W-1:0] out_scan
);
   logic take_new, take_old;

   assign take_new = evt && scan_done;
   assign take_old = evt && !scan_done && held_ok;

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_scan  <= '0;
      end else begin
         out_valid <= take_new || take_old;
         if (take_new)      out_scan <= scan_now;
         else if (take_old) out_scan <= held_scan;
      end
   end

   // R7: a valid output needs a finished scan one cycle earlier
   p_need_scan_r7: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> $past(held_ok || scan_done));

   // R6: a collision between completion and event takes the fresh scan
   p_new_wins_r6: assert property (@(posedge clk) disable iff (rst)
      (evt && scan_done) |=> (out_scan == $past(scan_now)));

   // R10: the captured scan only moves together with the valid pulse
   p_hold_r10: assert property (@(posedge clk) disable iff (rst)
      !out_valid |-> $stable(out_scan));
endmodule

// File: rtl/scan_capture_top.sv
module scan_capture_top #(
   parameter int NUM_CH      = 16,
   parameter int WORD_W      = 16,
   parameter int DIV_RATIO   = 8,
   parameter bit SCAN_RISING = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       mode_div,
   input  logic                       scan_clk,
   input  logic                       master_tick,
   input  logic                       in_valid,
   input  logic                       in_sof,
   input  logic [WORD_W-1:0]          in_word,
   output logic                       out_valid,
   output logic [NUM_CH*WORD_W-1:0]   out_scan
);
   generate
      if (NUM_CH < 2)    begin : g_bad_ch  $error("NUM_CH must be at least 2");    end
      if (WORD_W < 1)    begin : g_bad_w   $error("WORD_W must be positive");      end
      if (DIV_RATIO < 2) begin : g_bad_div $error("DIV_RATIO must be at least 2"); end
   endgenerate

   logic [NUM_CH-1:0][WORD_W-1:0] scan_now, held_scan, cap_scan;
   logic                          scan_done, held_ok, evt;

   scan_assembler #(.NUM_CH(NUM_CH), .WORD_W(WORD_W)) u_asm (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_word(in_word),
      .scan_now(scan_now), .scan_done(scan_done), .held_scan(held_scan), .held_ok(held_ok)
   );

   scan_event_gen #(.DIV_RATIO(DIV_RATIO), .SCAN_RISING(SCAN_RISING)) u_evt (
      .clk(clk), .rst(rst), .mode_div(mode_div), .scan_clk(scan_clk),
      .master_tick(master_tick), .evt(evt)
   );

   scan_capture_reg #(.NUM_CH(NUM_CH), .WORD_W(WORD_W)) u_cap (
      .clk(clk), .rst(rst), .evt(evt), .scan_done(scan_done), .scan_now(scan_now),
      .held_scan(held_scan), .held_ok(held_ok), .out_valid(out_valid), .out_scan(cap_scan)
   );

   assign out_scan = cap_scan;
endmodule

// File: tb/sim_scan_capture_top.sv
module sim_scan_capture_top;
   localparam int NCH = 16;
   localparam int WW  = 16;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic mode_div = 1'b0, scan_clk = 1'b0, master_tick = 1'b0;
   logic in_valid = 1'b0, in_sof = 1'b0;
   logic [WW-1:0] in_word = '0;
   logic out_valid;
   logic [NCH*WW-1:0] out_scan;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   scan_capture_top u0 (
      .clk(clk), .rst(rst), .mode_div(mode_div), .scan_clk(scan_clk),
      .master_tick(master_tick), .in_valid(in_valid), .in_sof(in_sof),
      .in_word(in_word), .out_valid(out_valid), .out_scan(out_scan)
   );

   function automatic logic [WW-1:0] pat(input int id, input int k);
      return WW'((id * 131 + k * 17 + 3) & 16'hFFFF);
   endfunction

   function automatic logic [NCH*WW-1:0] exp_scan(input int id);
      logic [NCH*WW-1:0] v;
      for (int k = 0; k < NCH; k++) v[k*WW +: WW] = pat(id, k);
      return v;
   endfunction

   task automatic chk_valid(input logic e, input string tag);
      checks++;
      if (out_valid !== e) begin
         errors++;
         $display("FAIL %s out_valid actual %b expected %b", tag, out_valid, e);
      end
   endtask

   task automatic chk_vec(input logic [NCH*WW-1:0] e, input string tag);
      checks++;
      if (out_scan !== e) begin
         errors++;
         $display("FAIL %s out_scan actual %h expected %h", tag, out_scan, e);
      end
   endtask

   // drive one cycle's inputs at a falling edge, then wait for the next falling edge
   task automatic cyc(input logic v, input logic s, input logic [WW-1:0] d,
                      input logic sc, input logic mt);
      in_valid = v; in_sof = s; in_word = d; scan_clk = sc; master_tick = mt;
      @(negedge clk);
   endtask

   task automatic send_scan(input int id, input int n);
      for (int k = 0; k < n; k++) cyc(1'b1, k == 0, pat(id, k), 1'b0, 1'b0);
   endtask

   task automatic edge_expect(input int id, input string tag);
      cyc(1'b0, 1'b0, '0, 1'b1, 1'b0);
      chk_valid(1'b1, tag);
      chk_vec(exp_scan(id), tag);
      cyc(1'b0, 1'b0, '0, 1'b0, 1'b0);
      chk_valid(1'b0, tag);
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int ticks;
      logic t, ev;
      repeat (3) @(negedge clk);
      chk_valid(1'b0, "R1 in reset");
      chk_vec('0, "R1 in reset");
      rst = 1'b0;
      cyc(1'b0, 1'b0, '0, 1'b0, 1'b0);
      chk_valid(1'b0, "R1 after reset");
      chk_vec('0, "R1 after reset");

      // R7: edge before any complete scan
      cyc(1'b0, 1'b0, '0, 1'b1, 1'b0);
      chk_valid(1'b0, "R7 no scan yet");
      cyc(1'b0, 1'b0, '0, 1'b0, 1'b0);
      send_scan(1, NCH - 1);
      cyc(1'b0, 1'b0, '0, 1'b1, 1'b0);
      chk_valid(1'b0, "R7 partial only");
      cyc(1'b0, 1'b0, '0, 1'b0, 1'b0);

      // R2 / R4: full scan then an edge
      send_scan(2, NCH);
      edge_expect(2, "R2 R4 first capture");
      repeat (5) cyc(1'b0, 1'b0, '0, 1'b0, 1'b0);
      chk_valid(1'b0, "R10 idle");
      chk_vec(exp_scan(2), "R10 hold");

      // R5 sweep over every trailing partial length
      for (int p = 0; p < NCH; p++) begin
         send_scan(10 + p, NCH);
         send_scan(50 + p, p);
         edge_expect(10 + p, "R5 partial sweep");
      end

      // R3: restart mid-scan, then stray words without start mark
      send_scan(80, 7);
      send_scan(81, NCH);
      for (int k = 0; k < 3; k++) cyc(1'b1, 1'b0, 16'hDEAD, 1'b0, 1'b0);
      edge_expect(81, "R3 restart and stray words");

      // R6: final word and edge on the same clock edge
      send_scan(90, NCH - 1);
      cyc(1'b1, 1'b0, pat(90, NCH - 1), 1'b1, 1'b0);
      chk_valid(1'b1, "R6 collision");
      chk_vec(exp_scan(90), "R6 collision");
      cyc(1'b0, 1'b0, '0, 1'b0, 1'b0);

      // R9: master ticks ignored in gated mode
      for (int i = 0; i < 20; i++) begin
         cyc(1'b0, 1'b0, '0, 1'b0, 1'b1);
         chk_valid(1'b0, "R9 tick in gated mode");
      end

      // R8: divided mode with irregular ticks and a toggling scan clock
      mode_div = 1'b1;
      ticks = 0;
      for (int i = 0; i < 60; i++) begin
         t = (i % 3) != 1;
         if (t) ticks++;
         ev = t && (ticks % 8 == 0);
         cyc(1'b0, 1'b0, '0, logic'(i % 2), t);
         chk_valid(ev, "R8 divided sweep");
         if (ev) chk_vec(exp_scan(90), "R8 divided data");
      end

      // R8: counter cleared while gated
      cyc(1'b0, 1'b0, '0, 1'b0, 1'b0);
      mode_div = 1'b1;
      for (int i = 0; i < 7; i++) begin
         cyc(1'b0, 1'b0, '0, 1'b0, 1'b1);
         chk_valid(1'b0, "R8 pre-clear ticks");
      end
      mode_div = 1'b0;
      cyc(1'b0, 1'b0, '0, 1'b0, 1'b0);
      mode_div = 1'b1;
      for (int i = 0; i < 7; i++) begin
         cyc(1'b0, 1'b0, '0, 1'b0, 1'b1);
         chk_valid(1'b0, "R8 counter restarted");
      end
      send_scan(95, NCH);
      cyc(1'b0, 1'b0, '0, 1'b0, 1'b1);
      chk_valid(1'b1, "R8 eighth tick");
      chk_vec(exp_scan(95), "R8 eighth tick");
      mode_div = 1'b0;
      cyc(1'b0, 1'b0, '0, 1'b0, 1'b0);

      // R1 / R7 after a second reset
      rst = 1'b1;
      repeat (2) cyc(1'b0, 1'b0, '0, 1'b0, 1'b0);
      chk_valid(1'b0, "R1 second reset");
      chk_vec('0, "R1 second reset");
      rst = 1'b0;
      cyc(1'b0, 1'b0, '0, 1'b1, 1'b0);
      chk_valid(1'b0, "R7 after second reset");
      cyc(1'b0, 1'b0, '0, 1'b0, 1'b0);
      send_scan(99, NCH);
      edge_expect(99, "R4 after second reset");

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule